// File: doc/BRIEF.md
# Multiple-Input Signature Compactor with Golden Compare

This block compresses a stream of 4-bit response words from a circuit under test into a 4-bit signature. Every stage of a small shift register takes its own data bit through an XOR beside the shift path, and the stage that closes the loop also takes feedback from two taps. A start pulse loads a seed and latches how many words to take. The block then folds one word into the signature on each clock where enable is high. After the last word it compares the signature with a golden value and reports the result.

The register is linear, so the same seed and the same word stream always give the same signature. Folding loses information, so some faulty streams can still produce the golden value. One feedback select replaces every XOR with an XNOR. With this option an all-zero register is a normal working state.

Top module: `misr_sig_check`

## Requirements
- R1: While rst_ni is low, sig_o, done_o and pass_o are all 0.
- R2: A clock edge with start_i high loads seed_i into sig_o, latches word_cnt_i as the word target, clears the accepted-word count, and clears pass_o when the target is nonzero. It also restarts any run already in progress.
- R3: With xnor_sel_i low, an accepted word d turns signature s into n, where n[0] = s[3]^s[2]^d[0] and n[k] = s[k-1]^d[k] for k = 1..3. This is the polynomial x^4 + x^3 + 1, and bit 0 is the first stage.
- R4: With xnor_sel_i high, each bit of n is the complement of the R3 value.
- R5: A word is accepted only while a run is active and en_i is high. In every other cycle sig_o holds its value, including when en_i is high after the run has ended.
- R6: done_o is high for exactly the one cycle that follows the clock edge that accepts the target-th word. In that cycle sig_o shows the final signature.
- R7: At the end of a run, pass_o becomes 1 if the final signature equals golden_i and 0 if not. It holds that value until the next start.
- R8: A start with word_cnt_i of zero accepts no words. done_o pulses in the cycle after the start, and pass_o reports whether seed_i equals golden_i.
- R9: Replaying the same seed and the same stream reproduces the signature. Flipping a single bit in one word of a stream gives a different signature, so pass_o reads 0 against the clean stream's golden value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the seed and the word target, and begin a run |
| en_i | input | 1 | Word valid; folds data_i into the signature |
| data_i | input | 4 | Response word |
| seed_i | input | 4 | Starting signature |
| golden_i | input | 4 | Expected signature of a fault-free stream |
| word_cnt_i | input | 8 | Number of words in a run |
| xnor_sel_i | input | 1 | 1 selects XNOR combining, 0 selects XOR |
| sig_o | output | 4 | Current signature |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result of the compare, held until the next start |

## Verification
The embedded properties check on every cycle that a start loads the seed, that the signature holds whenever no word is accepted, and that the word count stays below its target during a run. They also check that done_o only pulses once the run has ended and that pass_o changes only at a start or a done pulse. The exact signature values under both feedback modes can only be shown by the bench's scenarios, which sweep all seeds against a word-by-word model. The same holds for the zero-count case, determinism on replay, and detection of a single flipped bit.

// File: rtl/misr_pkg.sv
package misr_pkg;
  localparam int unsigned SIG_W = 4;
  localparam int unsigned CNT_W = 8;
  // taps for x^4 + x^3 + 1: last two stages
  localparam logic [SIG_W-1:0] TAP_MASK = 4'b1100;
  typedef logic [SIG_W-1:0] sig_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/misr_reg.sv
module misr_reg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TAPS = 4'b1100
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  input  logic         xnor_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sig_q_o,
  output logic [W-1:0] sig_d_o
);
  logic [W-1:0] sig_q;
  logic         fb;

  assign fb = ^(sig_q & TAPS);

  for (genvar k = 0; k < W; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign sig_d_o[k] = fb ^ data_i[k] ^ xnor_i;
    end else begin : g_rest
      assign sig_d_o[k] = sig_q[k-1] ^ data_i[k] ^ xnor_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= '0;
    else if (load_i) sig_q <= seed_i;
    else if (step_i) sig_q <= sig_d_o;
  end

  assign sig_q_o = sig_q;

  p_seed_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sig_q == $past(seed_i));
  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(sig_q));
endmodule

// File: rtl/misr_ctrl.sv
module misr_ctrl #(
  parameter int unsigned W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [W-1:0]     seed_i,
  input  logic [W-1:0]     golden_i,
  input  logic [W-1:0]     sig_nxt_i,
  output logic             step_o,
  output logic             done_o,
  output logic             pass_o
);
  logic             busy_q, done_q, pass_q, last;
  logic [CNT_W-1:0] cnt_q, tgt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign step_o  = busy_q && en_i && !start_i;
  assign last    = step_o && (cnt_inc == {1'b0, tgt_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else if (start_i) begin
      busy_q <= (word_cnt_i != '0);
      done_q <= (word_cnt_i == '0);
      pass_q <= (word_cnt_i == '0) && (seed_i == golden_i);
      cnt_q  <= '0;
      tgt_q  <= word_cnt_i;
    end else begin
      done_q <= last;
      if (step_o) cnt_q <= cnt_inc[CNT_W-1:0];
      if (last) begin
        busy_q <= 1'b0;
        pass_q <= (sig_nxt_i == golden_i);
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  p_cnt_below_tgt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < tgt_q);
  p_done_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/misr_sig_check.sv
module misr_sig_check
  import misr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [SIG_W-1:0] data_i,
  input  logic [SIG_W-1:0] seed_i,
  input  logic [SIG_W-1:0] golden_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic             xnor_sel_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             done_o,
  output logic             pass_o
);
  sig_t sig_nxt;
  logic step;

  misr_reg #(.W(SIG_W), .TAPS(TAP_MASK)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .seed_i  (seed_i),
    .step_i  (step),
    .xnor_i  (xnor_sel_i),
    .data_i  (data_i),
    .sig_q_o (sig_o),
    .sig_d_o (sig_nxt)
  );

  misr_ctrl #(.W(SIG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .en_i       (en_i),
    .word_cnt_i (word_cnt_i),
    .seed_i     (seed_i),
    .golden_i   (golden_i),
    .sig_nxt_i  (sig_nxt),
    .step_o     (step),
    .done_o     (done_o),
    .pass_o     (pass_o)
  );

  p_pass_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_o) |-> (done_o || $past(start_i)));
  p_pass_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);
endmodule

// File: tb/misr_sig_check_tb.sv
module misr_sig_check_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, en = 1'b0, xs = 1'b0;
  logic [3:0] data = '0, seed = '0, golden = '0;
  logic [7:0] wcnt = '0;
  logic [3:0] sig;
  logic       done, pass;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  misr_sig_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .en_i(en), .data_i(data),
    .seed_i(seed), .golden_i(golden), .word_cnt_i(wcnt), .xnor_sel_i(xs),
    .sig_o(sig), .done_o(done), .pass_o(pass)
  );

  function automatic logic [3:0] model(input logic [3:0] s, input logic [3:0] d, input logic x);
    logic [3:0] n;
    n[0] = s[3] ^ s[2] ^ d[0];
    n[1] = s[0] ^ d[1];
    n[2] = s[1] ^ d[2];
    n[3] = s[2] ^ d[3];
    return x ? ~n : n;
  endfunction

  function automatic logic [3:0] word_of(input int sd, input int i, input int m);
    return 4'((sd * 3 + i * 5 + m * 7 + i * i) & 15);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [3:0] s, input logic [7:0] n, input logic [3:0] g);
    seed = s; wcnt = n; golden = g; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [3:0] d);
    data = d; en = 1'b1;
    @(posedge clk); @(negedge clk);
    en = 1'b0;
  endtask

  // full run of NW words, optional bit flip in word err_w; returns final signature
  task automatic run(input int sd, input int m, input int nw, input logic [3:0] g,
                     input int err_w, input logic [3:0] err_mask,
                     output logic [3:0] fin, output bit d_ok);
    logic [3:0] w;
    do_start(4'(sd), 8'(nw), g);
    d_ok = 1'b1;
    for (int i = 0; i < nw; i++) begin
      w = word_of(sd, i, m);
      if (i == err_w) w = w ^ err_mask;
      if (done) d_ok = 1'b0;
      push(w);
    end
    fin = sig;
    if (!done) d_ok = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] exp_s, fin, fin2, s0;
    bit dk;
    repeat (3) @(negedge clk);
    chk(sig == 0 && !done && !pass, "R1 reset state", {sig, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R8: zero-count run
    do_start(4'h9, 8'd0, 4'h9);
    chk(sig == 4'h9, "R2 seed load", sig, 9);
    chk(done && pass, "R8 zero count match", {done, pass}, 3);
    @(negedge clk);
    chk(!done && pass, "R6 done one cycle / R7 hold", {done, pass}, 1);
    do_start(4'h9, 8'd0, 4'h3);
    chk(done && !pass, "R8 zero count mismatch", {done, pass}, 2);

    // R3/R4/R6/R7 sweep: every seed, both modes
    for (int m = 0; m < 2; m++) begin
      xs = 1'(m);
      for (int sd = 0; sd < 16; sd++) begin
        exp_s = 4'(sd);
        for (int i = 0; i < 6; i++) exp_s = model(exp_s, word_of(sd, i, m), 1'(m));
        run(sd, m, 6, exp_s, -1, 4'h0, fin, dk);
        chk(fin == exp_s, m ? "R4 xnor signature" : "R3 xor signature", fin, exp_s);
        chk(dk, "R6 done timing", 0, 1);
        chk(pass, "R7 pass on match", pass, 1);
        @(negedge clk);
        chk(!done && pass && sig == exp_s, "R6 R7 after done", {done, pass, sig}, {2'b01, exp_s});
        // R5: enable after end has no effect
        push(4'hF);
        chk(sig == exp_s && pass, "R5 idle enable ignored", sig, exp_s);
      end
    end

    // R3 single step check from zero state under XNOR: all-zero is not stuck
    xs = 1'b1;
    do_start(4'h0, 8'd1, 4'hF);
    push(4'h0);
    chk(sig == 4'hF && pass, "R4 zero state steps to F", sig, 15);

    // R5: en low mid-run holds signature
    xs = 1'b0;
    do_start(4'h5, 8'd3, 4'h0);
    push(4'hA);
    s0 = sig;
    en = 1'b0; data = 4'h7;
    repeat (3) @(negedge clk);
    chk(sig == s0, "R5 hold while en low", sig, s0);
    chk(sig == model(4'h5, 4'hA, 1'b0), "R3 single step", sig, model(4'h5, 4'hA, 1'b0));

    // R2: restart mid-run clears pass and reloads
    do_start(4'hC, 8'd2, 4'h0);
    chk(sig == 4'hC && !pass && !done, "R2 restart", {sig, pass, done}, {4'hC, 2'b00});

    // R9: replay and single-bit error for each word and bit
    for (int sd = 1; sd < 16; sd += 7) begin
      exp_s = 4'(sd);
      for (int i = 0; i < 5; i++) exp_s = model(exp_s, word_of(sd, i, 0), 1'b0);
      run(sd, 0, 5, exp_s, -1, 4'h0, fin, dk);
      run(sd, 0, 5, exp_s, -1, 4'h0, fin2, dk);
      chk(fin == fin2 && pass, "R9 replay", fin2, fin);
      for (int ew = 0; ew < 5; ew++)
        for (int b = 0; b < 4; b++) begin
          run(sd, 0, 5, exp_s, ew, 4'(1 << b), fin, dk);
          chk(fin != exp_s && !pass, "R9 single bit error detected", {fin, pass}, {exp_s, 1'b0});
        end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule